// File: doc/BRIEF.md
# Power-State Control Sequencer

This block is the supervisory state machine of a power-management unit. It watches three startup request lines (a power button, a hands-free power line and a charger-present line), a power-hold line kept high by the host while it wants power, and a signed die-temperature code in degrees Celsius. From these it drives a single global regulator enable. Request lines pass through a two-flop synchronizer and only their rising edges start the unit, so a request that is simply held does not power the unit up again after a shutdown.

Over-temperature protection uses two thresholds. The unit trips off above the upper one and may come back only below the lower one. A control bit selects what follows a trip. With the bit clear the unit performs a full cold shutdown and waits for a fresh request. With the bit set it waits, with its registers intact, and restarts by itself once the die has cooled. While the unit is on, a loss of power-hold lasting one of two selectable timeouts also shuts it down.

A byte-wide register port gives access to two registers. One is a read-only status register recording which request or requests caused the latest cold start. The other is a control register holding the restart mode and the timeout select.

Top module: `pmu_state_sequencer`

## Requirements
- R1: After reset the regulator enable is 0, and both the status register (address 0x0C) and the control register (address 0x1C) read 0.
- R2: While off, a rising edge on any request input powers the unit up, provided the temperature is below 115. A request that has been held high since before the unit was off does not power it up.
- R3: Status register at 0x0C: bit 7 marks the power button, bit 6 hands-free power and bit 5 the charger line. All requests whose edges start the unit in the same cycle are recorded. The register is rewritten at each cold start, bits 4..0 read 0, and writes to it are ignored.
- R4: Control register at 0x1C: bit 1 is the auto-restart enable and bit 0 the long power-hold timeout select. Bits 7..2 read 0, and any other address reads 0.
- R5: While on, a temperature code above 160 drops the enable on the next clock edge. A code of exactly 160 does not.
- R6: A power-up from the off state is refused while the temperature is 115 or higher. The request edge is then consumed.
- R7: A trip with auto-restart 0 is a full shutdown. The unit stays off after cooling until a new request edge arrives.
- R8: A trip with auto-restart 1 powers the unit up again once the temperature drops below 115, and not at 115. The status and control registers keep their contents across the restart.
- R9: While on, power-hold held low continuously for 35 ms (select 0) or 350 ms (select 1) shuts the unit down. Any return of power-hold to high restarts the timing.
- R10: Every full shutdown clears the control register to 0. A control write in the same cycle as a full shutdown is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_req_i | input | 1 | Power button request, asynchronous |
| hf_req_i | input | 1 | Hands-free power request, asynchronous |
| chg_req_i | input | 1 | Charger-present request, asynchronous |
| hold_i | input | 1 | Power-hold from host, asynchronous |
| temp_i | input | TEMP_W | Signed die temperature, degrees C, synchronous |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational on address |
| pwr_en_o | output | 1 | Global regulator enable |

## Verification
A thermal trip with auto-restart clear and a control-register write can land on the same clock edge. The two disagree: the write wants to set the control bits, and the shutdown wants them cleared. The bench provokes this by driving a hot temperature code and a write of 0x03 to the control register in one cycle. It then expects the enable low and the control register reading 0, because the shutdown decision uses the auto-restart bit as it stood before the write.

// File: rtl/pmu_seq_pkg.sv
`timescale 1ns/1ps
package pmu_seq_pkg;

   typedef enum logic [1:0] {
      PS_OFF   = 2'd0,
      PS_ON    = 2'd1,
      PS_TWAIT = 2'd2
   } pmu_state_e;

   localparam int unsigned REQ_N   = 3;
   localparam int unsigned REQ_BTN = 0;
   localparam int unsigned REQ_HF  = 1;
   localparam int unsigned REQ_CHG = 2;

endpackage

// File: rtl/pmu_edge_sync.sv
`timescale 1ns/1ps
module pmu_edge_sync #(
   parameter int unsigned N      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] in_i,
   output logic [N-1:0] rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pmu_edge_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < N; g++) begin : g_bit
      logic [STAGES:0] shreg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) shreg <= '0;
         else        shreg <= {shreg[STAGES-1:0], in_i[g]};
      end
      assign rise_o[g] = shreg[STAGES-1] & ~shreg[STAGES];
   end

endmodule

// File: rtl/pmu_thermal.sv
`timescale 1ns/1ps
module pmu_thermal #(
   parameter int unsigned TEMP_W = 9,
   parameter int          HOT_C  = 160,
   parameter int          COOL_C = 115
) (
   input  logic signed [TEMP_W-1:0] temp_i,
   output logic                     hot_o,
   output logic                     cool_o
);

   localparam int TMAX = (1 << (TEMP_W - 1)) - 1;

   if (COOL_C >= HOT_C) begin : g_bad_hyst
      $error("pmu_thermal: COOL_C must lie below HOT_C");
   end
   if (HOT_C >= TMAX) begin : g_bad_width
      $error("pmu_thermal: TEMP_W too narrow for HOT_C");
   end

   localparam logic signed [TEMP_W-1:0] HOT_CODE  = TEMP_W'(HOT_C);
   localparam logic signed [TEMP_W-1:0] COOL_CODE = TEMP_W'(COOL_C);

   assign hot_o  = temp_i > HOT_CODE;
   assign cool_o = temp_i < COOL_CODE;

endmodule

// File: rtl/pmu_hold_timer.sv
`timescale 1ns/1ps
module pmu_hold_timer #(
   parameter int unsigned TICKS_PER_MS = 1000,
   parameter int unsigned SHORT_MS     = 35,
   parameter int unsigned LONG_MS      = 350
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic long_i,
   input  logic hold_i,
   output logic expire_o
);

   localparam int unsigned SHORT_CYC = TICKS_PER_MS * SHORT_MS;
   localparam int unsigned LONG_CYC  = TICKS_PER_MS * LONG_MS;
   localparam int unsigned CNT_W     = $clog2(LONG_CYC + 1);

   if (SHORT_MS == 0 || LONG_MS <= SHORT_MS || TICKS_PER_MS == 0) begin : g_bad_time
      $error("pmu_hold_timer: need 0 < SHORT_MS < LONG_MS and TICKS_PER_MS > 0");
   end

   logic [1:0]       hold_sync;
   logic             hold_s;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_sync <= 2'b00;
      else        hold_sync <= {hold_sync[0], hold_i};
   end
   assign hold_s = hold_sync[1];

   assign limit    = long_i ? CNT_W'(LONG_CYC - 1) : CNT_W'(SHORT_CYC - 1);
   assign expire_o = run_i && !hold_s && (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run_i || hold_s) cnt_q <= '0;
      else if (!expire_o)        cnt_q <= cnt_q + 1'b1;
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(LONG_CYC - 1)); // R9
   AST_HOLD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && hold_s) |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/pmu_regs.sv
`timescale 1ns/1ps
module pmu_regs #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned STAT_ADDR = 8'h0C,
   parameter int unsigned CTRL_ADDR = 8'h1C
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_i,
   input  logic [ADDR_W-1:0]             addr_i,
   input  logic [DATA_W-1:0]             wdata_i,
   input  logic                          clr_ctrl_i,
   input  logic                          stat_load_i,
   input  logic [pmu_seq_pkg::REQ_N-1:0] stat_src_i,
   output logic [DATA_W-1:0]             rdata_o,
   output logic                          auto_o,
   output logic                          long_o
);
   import pmu_seq_pkg::*;

   if (DATA_W < 8) begin : g_bad_data
      $error("pmu_regs: DATA_W must be at least 8");
   end
   if (STAT_ADDR == CTRL_ADDR) begin : g_bad_map
      $error("pmu_regs: register addresses must differ");
   end

   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

   logic [REQ_N-1:0] stat_q;
   logic [1:0]       ctrl_q;
   logic             ctrl_we;
   logic             unused_wdata_hi;

   assign ctrl_we         = wr_i && (addr_i == A_CTRL);
   assign unused_wdata_hi = ^wdata_i[DATA_W-1:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ctrl_q <= 2'b00;
      else if (clr_ctrl_i) ctrl_q <= 2'b00;
      else if (ctrl_we)    ctrl_q <= wdata_i[1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           stat_q <= '0;
      else if (stat_load_i) stat_q <= stat_src_i;
   end

   assign auto_o = ctrl_q[1];
   assign long_o = ctrl_q[0];

   always_comb begin
      rdata_o = '0;
      if (addr_i == A_STAT) begin
         rdata_o[7] = stat_q[REQ_BTN];
         rdata_o[6] = stat_q[REQ_HF];
         rdata_o[5] = stat_q[REQ_CHG];
      end else if (addr_i == A_CTRL) begin
         rdata_o[1:0] = ctrl_q;
      end
   end

   AST_CTRL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ctrl_i |=> (auto_o == 1'b0 && long_o == 1'b0)); // R10
   AST_STAT_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == A_STAT && !stat_load_i) |=> $stable(stat_q)); // R3

endmodule

// File: rtl/pmu_state_sequencer.sv
`timescale 1ns/1ps
module pmu_state_sequencer #(
   parameter int unsigned TICKS_PER_MS = 1000,
   parameter int unsigned SHORT_MS     = 35,
   parameter int unsigned LONG_MS      = 350,
   parameter int unsigned TEMP_W       = 9,
   parameter int          HOT_C        = 160,
   parameter int          COOL_C       = 115,
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     btn_req_i,
   input  logic                     hf_req_i,
   input  logic                     chg_req_i,
   input  logic                     hold_i,
   input  logic signed [TEMP_W-1:0] temp_i,
   input  logic [ADDR_W-1:0]        reg_addr_i,
   input  logic                     reg_wr_i,
   input  logic [DATA_W-1:0]        reg_wdata_i,
   output logic [DATA_W-1:0]        reg_rdata_o,
   output logic                     pwr_en_o
);
   import pmu_seq_pkg::*;

   pmu_state_e       state_q, state_d;
   logic [REQ_N-1:0] req_raw, req_rise;
   logic             hot, cool, expire;
   logic             auto_rst, long_hold;
   logic             full_off, stat_load;

   assign req_raw[REQ_BTN] = btn_req_i;
   assign req_raw[REQ_HF]  = hf_req_i;
   assign req_raw[REQ_CHG] = chg_req_i;

   pmu_edge_sync #(.N(REQ_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .in_i(req_raw), .rise_o(req_rise));

   pmu_thermal #(.TEMP_W(TEMP_W), .HOT_C(HOT_C), .COOL_C(COOL_C)) u_therm (
      .temp_i(temp_i), .hot_o(hot), .cool_o(cool));

   pmu_hold_timer #(.TICKS_PER_MS(TICKS_PER_MS), .SHORT_MS(SHORT_MS),
                    .LONG_MS(LONG_MS)) u_hold (
      .clk(clk), .rst_n(rst_n), .run_i(state_q == PS_ON), .long_i(long_hold),
      .hold_i(hold_i), .expire_o(expire));

   pmu_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
      .wdata_i(reg_wdata_i), .clr_ctrl_i(full_off), .stat_load_i(stat_load),
      .stat_src_i(req_rise), .rdata_o(reg_rdata_o), .auto_o(auto_rst),
      .long_o(long_hold));

   always_comb begin
      state_d   = state_q;
      full_off  = 1'b0;
      stat_load = 1'b0;
      unique case (state_q)
         PS_OFF: begin
            if ((|req_rise) && cool) begin
               state_d   = PS_ON;
               stat_load = 1'b1;
            end
         end
         PS_ON: begin
            if (hot) begin
               if (auto_rst) state_d = PS_TWAIT;
               else begin
                  state_d  = PS_OFF;
                  full_off = 1'b1;
               end
            end else if (expire) begin
               state_d  = PS_OFF;
               full_off = 1'b1;
            end
         end
         PS_TWAIT: begin
            if (cool) state_d = PS_ON;
         end
         default: state_d = PS_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PS_OFF;
      else        state_q <= state_d;
   end

   assign pwr_en_o = (state_q == PS_ON);

   AST_TRIP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_en_o && hot) |=> !pwr_en_o); // R5
   AST_NO_HOT_START: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_OFF && !cool) |=> (state_q == PS_OFF)); // R6
   AST_TWAIT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_TWAIT && !cool) |=> (state_q == PS_TWAIT)); // R8
   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_en_o && !hot && expire) |=> !pwr_en_o); // R9

endmodule

// File: tb/pmu_state_sequencer_tb_top.sv
`timescale 1ns/1ps
module pmu_state_sequencer_tb_top;

   localparam int TPM   = 4;
   localparam int SHORT = 35 * TPM;
   localparam int LONG  = 350 * TPM;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              btn = 1'b0, hf = 1'b0, chg = 1'b0, hold = 1'b0;
   logic signed [8:0] temp = 9'sd25;
   logic [7:0]        addr = 8'h00;
   logic              wr = 1'b0;
   logic [7:0]        wdata = 8'h00;
   logic [7:0]        rdata;
   logic              en;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pmu_state_sequencer #(.TICKS_PER_MS(TPM)) dut_i (
      .clk(clk), .rst_n(rst_n), .btn_req_i(btn), .hf_req_i(hf), .chg_req_i(chg),
      .hold_i(hold), .temp_i(temp), .reg_addr_i(addr), .reg_wr_i(wr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pwr_en_o(en));

   function automatic logic [7:0] stat_exp(input logic [2:0] m);
      return {m[0], m[1], m[2], 5'b00000};
   endfunction

   function automatic logic [7:0] read_exp(input logic [7:0] a, input logic [1:0] ctrl,
                                           input logic [7:0] stat);
      if (a == 8'h1C) return {6'b0, ctrl};
      if (a == 8'h0C) return stat;
      return 8'h00;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input string what, input logic [7:0] act,
                        input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic wreg(input logic [7:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr = 1'b1;
      tick(1);
      wr = 1'b0;
   endtask

   initial begin
      #(100000 * 10);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [1:0] ctrl_m;
      void'($urandom(32'd4242));
      tick(3);
      rst_n = 1'b1;
      tick(1);
      check("R1", "enable", {7'b0, en}, 8'h00);
      rd(8'h0C, d); check("R1", "status", d, 8'h00);
      rd(8'h1C, d); check("R1", "control", d, 8'h00);
      hold = 1'b1;

      // R4 / R3: random register traffic while off
      ctrl_m = 2'b00;
      for (int i = 0; i < 24; i++) begin
         logic [7:0] a, v;
         int sel;
         sel = $urandom_range(0, 2);
         a = (sel == 0) ? 8'h1C : (sel == 1) ? 8'h0C : 8'($urandom_range(0, 255));
         v = 8'($urandom_range(0, 255));
         wreg(a, v);
         if (a == 8'h1C) ctrl_m = v[1:0];
         rd(a, d);
         check((a == 8'h0C) ? "R3" : "R4", "random reg", d, read_exp(a, ctrl_m, 8'h00));
      end
      wreg(8'h1C, 8'h00);

      // R6: start refused at 115, edge consumed
      temp = 9'sd115; btn = 1'b1; tick(6);
      check("R6", "blocked at 115", {7'b0, en}, 8'h00);
      temp = 9'sd114; tick(6);
      check("R2", "held request no start", {7'b0, en}, 8'h00);
      btn = 1'b0; tick(4); btn = 1'b1; tick(4);
      check("R2", "edge start", {7'b0, en}, 8'h01);
      rd(8'h0C, d); check("R3", "status button", d, 8'h80);

      // R5 / R7: trip boundary, full shutdown
      wreg(8'h1C, 8'h01);
      temp = 9'sd160; tick(5);
      check("R5", "160 no trip", {7'b0, en}, 8'h01);
      temp = 9'sd161; tick(1);
      check("R5", "161 trips", {7'b0, en}, 8'h00);
      rd(8'h1C, d); check("R7", "control cleared", d, 8'h00);
      temp = 9'sd100; tick(10);
      check("R7", "no restart without edge", {7'b0, en}, 8'h00);
      btn = 1'b0; tick(4); hf = 1'b1; tick(4);
      check("R7", "fresh edge restarts", {7'b0, en}, 8'h01);

      // R8: auto restart
      wreg(8'h1C, 8'h03);
      temp = 9'sd170; tick(1);
      check("R8", "trip off", {7'b0, en}, 8'h00);
      temp = 9'sd115; tick(10);
      check("R8", "waits at 115", {7'b0, en}, 8'h00);
      temp = 9'sd114; tick(1);
      check("R8", "restart at 114", {7'b0, en}, 8'h01);
      rd(8'h1C, d); check("R8", "control kept", d, 8'h03);
      rd(8'h0C, d); check("R8", "status kept", d, 8'h40);

      // R9: short timeout with restart of timing
      hf = 1'b0;
      wreg(8'h1C, 8'h02);
      hold = 1'b0; tick(100); hold = 1'b1; tick(3); hold = 1'b0; tick(SHORT - 20);
      check("R9", "timer restarted", {7'b0, en}, 8'h01);
      tick(30);
      check("R9", "short timeout", {7'b0, en}, 8'h00);
      rd(8'h1C, d); check("R10", "cleared on hold loss", d, 8'h00);

      // R9: long timeout
      hold = 1'b1; chg = 1'b1; tick(4);
      check("R2", "charger start", {7'b0, en}, 8'h01);
      rd(8'h0C, d); check("R3", "status charger", d, 8'h20);
      wreg(8'h1C, 8'h01);
      hold = 1'b0; tick(LONG - 10);
      check("R9", "long not yet", {7'b0, en}, 8'h01);
      tick(20);
      check("R9", "long timeout", {7'b0, en}, 8'h00);

      // R10: trip and control write in one cycle
      hold = 1'b1; chg = 1'b0; btn = 1'b0; tick(4); btn = 1'b1; tick(4);
      check("R2", "button start", {7'b0, en}, 8'h01);
      temp = 9'sd170; addr = 8'h1C; wdata = 8'h03; wr = 1'b1;
      tick(1);
      wr = 1'b0;
      check("R10", "collision off", {7'b0, en}, 8'h00);
      rd(8'h1C, d); check("R10", "collision write lost", d, 8'h00);
      temp = 9'sd25; btn = 1'b0; tick(4);

      // R3: random simultaneous request masks
      for (int i = 0; i < 6; i++) begin
         logic [2:0] m;
         m = 3'($urandom_range(1, 7));
         btn = m[0]; hf = m[1]; chg = m[2];
         tick(4);
         check("R2", "mask start", {7'b0, en}, 8'h01);
         rd(8'h0C, d); check("R3", "mask status", d, stat_exp(m));
         temp = 9'sd170; tick(1);
         check("R5", "mask trip", {7'b0, en}, 8'h00);
         temp = 9'sd25; btn = 1'b0; hf = 1'b0; chg = 1'b0; tick(4);
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule